// File: doc/BRIEF.md
# Serial Synthesizer Programming Port

This block is the programming port of a dual-loop frequency synthesizer. Three slow wires come in from a controller: a shift clock, a data line and a strobe. The block brings all three into the system clock domain and finds their rising edges. It shifts the data line in, most significant bit first, on every rising edge of the shift clock. When the strobe rises, it moves the last 23 bits into one of two holding latches.

The two lowest bits of the word are a destination code. One code selects the reference-divider latch. That latch holds the reference count, the test-select pair, the prescaler mode and the two test enables. The other code selects the main-divider latch, which holds the N count, the A count and the comparator polarity. Any other code, or a strobe that follows fewer than 23 shifted bits, leaves both latches untouched.

A small decoder turns the output-test enable and the test-select pair into a selector. The selector tells the lock-detect pin multiplexer whether to show the lock flag or one of four divider outputs.

Top module: `synth_prog_if`

## Requirements
- R1: After reset every latched field is zero and `ld_sel` is 3'b000.
- R2: A bit is captured on each rising edge of `ser_clk`, and the word is built most significant bit first. When more than 23 bits arrive before a strobe, only the last 23 count: the last bit sent is word bit 0.
- R3: A strobe with word bits [1:0] = 2'b10 loads the reference latch with these fields: `ref_div` = bits [17:4], `test_sel` = bits [3:2], `ctr_test` = bit 20, `out_test` = bit 21, `presc_sel` = bit 22.
- R4: A strobe with word bits [1:0] = 2'b11 loads the main latch with these fields: `main_n` = bits [22:12], `main_a` = bits [11:5], `pd_pol` = bit 4.
- R5: A strobe with word bits [1:0] equal to 2'b00 or 2'b01 changes no output.
- R6: A strobe that arrives when fewer than 23 bits have been shifted since the previous strobe (or since reset) changes no output. Every strobe restarts the bit count, whether it was accepted or not.
- R7: Loading one latch leaves every field of the other latch unchanged.
- R8: `ld_sel` is 3'b000 when `out_test` is 0. When `out_test` is 1, `ld_sel` is {1'b1, `test_sel`}, with this meaning for `test_sel`: 00 = second-loop reference divider, 01 = second-loop main divider, 10 = first-loop reference divider, 11 = first-loop main divider.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Shift clock, active high, asynchronous |
| ser_data | input | 1 | Serial data, most significant bit first |
| ser_strobe | input | 1 | Load strobe, active high |
| ref_div | output | 14 | Reference divider count |
| test_sel | output | 2 | Test-select pair |
| presc_sel | output | 1 | Prescaler mode (0 = 128/129, 1 = 64/65) |
| ctr_test | output | 1 | Counter test enable |
| out_test | output | 1 | Lock-detect pin test enable |
| main_n | output | 11 | Main N count |
| main_a | output | 7 | Main A count (swallow count) |
| pd_pol | output | 1 | Comparator polarity (0 = negative, 1 = positive) |
| ld_sel | output | 3 | Lock-detect pin source selector |

## Verification
Random 23-bit words are sent with all four destination codes. These show whether each field is taken from the right bit positions, and whether the wrong code, or the latch that was not addressed, stays put. Directed words of all ones and of alternating bits expose swapped or shifted fields. A ten-bit burst followed by a strobe separates a correct bit count from one that accepts any strobe. A 30-bit burst separates a window that keeps the last 23 bits from one that keeps the first 23. The test enable and all four test-select values are walked through to pin down the selector encoding.

// File: rtl/synth_prog_pkg.sv
package synth_prog_pkg;
  localparam int WORD_W = 23;
  localparam int R_W    = 14;
  localparam int N_W    = 11;
  localparam int A_W    = 7;
  localparam int T_W    = 2;
  localparam int CODE_W = 2;
  localparam int SEL_W  = T_W + 1;
  localparam int CNT_W  = $clog2(WORD_W + 1);

  localparam int T_LSB  = CODE_W;
  localparam int R_LSB  = T_LSB + T_W;
  localparam int TC_BIT = 20;
  localparam int TO_BIT = 21;
  localparam int P_BIT  = 22;
  localparam int PD_BIT = CODE_W + 2;
  localparam int A_LSB  = PD_BIT + 1;
  localparam int N_LSB  = A_LSB + A_W;

  localparam logic [CODE_W-1:0] CODE_REF  = 2'b10;
  localparam logic [CODE_W-1:0] CODE_MAIN = 2'b11;

  typedef struct packed {
    logic [R_W-1:0] r;
    logic [T_W-1:0] t;
    logic           p;
    logic           tc;
    logic           to;
  } ref_word_t;

  typedef struct packed {
    logic [N_W-1:0] n;
    logic [A_W-1:0] a;
    logic           pd;
  } main_word_t;

  function automatic ref_word_t unpack_ref(input logic [WORD_W-1:0] w);
    ref_word_t f;
    f.r  = w[R_LSB +: R_W];
    f.t  = w[T_LSB +: T_W];
    f.p  = w[P_BIT];
    f.tc = w[TC_BIT];
    f.to = w[TO_BIT];
    return f;
  endfunction

  function automatic main_word_t unpack_main(input logic [WORD_W-1:0] w);
    main_word_t f;
    f.n  = w[N_LSB +: N_W];
    f.a  = w[A_LSB +: A_W];
    f.pd = w[PD_BIT];
    return f;
  endfunction

  function automatic logic [SEL_W-1:0] ld_select(input logic to, input logic [T_W-1:0] t);
    return to ? {1'b1, t} : '0;
  endfunction
endpackage

// File: rtl/sp_sync_edge.sv
module sp_sync_edge #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] level,
  output logic [WIDTH-1:0] rise
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic [STAGES:0] pipe;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= '0;
      else        pipe <= {pipe[STAGES-1:0], async_in[g]};
    end
    assign level[g] = pipe[STAGES-1];
    assign rise[g]  = pipe[STAGES-1] & ~pipe[STAGES];
  end
endmodule

// File: rtl/sp_shifter.sv
module sp_shifter
  import synth_prog_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              bit_in,
  input  logic              clear,
  output logic [WORD_W-1:0] word,
  output logic              full
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word <= '0;
      cnt  <= '0;
    end else begin
      if (shift_en) word <= {word[WORD_W-2:0], bit_in};
      if (clear) cnt <= '0;
      else if (shift_en && cnt != CNT_W'(WORD_W)) cnt <= cnt + 1'b1;
    end
  end

  assign full = (cnt == CNT_W'(WORD_W));
endmodule

// File: rtl/sp_latch.sv
module sp_latch
  import synth_prog_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe,
  input  logic              full,
  input  logic [WORD_W-1:0] word,
  output logic              load_ref,
  output logic              load_main,
  output ref_word_t         ref_q,
  output main_word_t        main_q
);
  logic accept;
  assign accept    = strobe & full;
  assign load_ref  = accept & (word[CODE_W-1:0] == CODE_REF);
  assign load_main = accept & (word[CODE_W-1:0] == CODE_MAIN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q  <= '0;
      main_q <= '0;
    end else begin
      if (load_ref)  ref_q  <= unpack_ref(word);
      if (load_main) main_q <= unpack_main(word);
    end
  end
endmodule

// File: rtl/synth_prog_if.sv
module synth_prog_if
  import synth_prog_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_clk,
  input  logic             ser_data,
  input  logic             ser_strobe,
  output logic [R_W-1:0]   ref_div,
  output logic [T_W-1:0]   test_sel,
  output logic             presc_sel,
  output logic             ctr_test,
  output logic             out_test,
  output logic [N_W-1:0]   main_n,
  output logic [A_W-1:0]   main_a,
  output logic             pd_pol,
  output logic [SEL_W-1:0] ld_sel
);
  logic [2:0] lvl, rise;
  logic              clk_rise, stb_rise, data_bit;
  logic [WORD_W-1:0] shift_word;
  logic              word_full, load_ref, load_main;
  ref_word_t         ref_q;
  main_word_t        main_q;

  sp_sync_edge #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .async_in({ser_strobe, ser_data, ser_clk}),
    .level(lvl), .rise(rise)
  );
  assign clk_rise = rise[0];
  assign data_bit = lvl[1];
  assign stb_rise = rise[2];

  sp_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .shift_en(clk_rise), .bit_in(data_bit),
    .clear(stb_rise), .word(shift_word), .full(word_full)
  );

  sp_latch u_latch (
    .clk(clk), .rst_n(rst_n), .strobe(stb_rise), .full(word_full),
    .word(shift_word), .load_ref(load_ref), .load_main(load_main),
    .ref_q(ref_q), .main_q(main_q)
  );

  assign ref_div   = ref_q.r;
  assign test_sel  = ref_q.t;
  assign presc_sel = ref_q.p;
  assign ctr_test  = ref_q.tc;
  assign out_test  = ref_q.to;
  assign main_n    = main_q.n;
  assign main_a    = main_q.a;
  assign pd_pol    = main_q.pd;
  assign ld_sel    = ld_select(ref_q.to, ref_q.t);
endmodule

// File: rtl/synth_prog_chk.sv
module synth_prog_chk
  import synth_prog_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              stb_rise,
  input logic              word_full,
  input logic              load_ref,
  input logic              load_main,
  input logic [WORD_W-1:0] shift_word,
  input logic [R_W-1:0]    ref_div,
  input logic [N_W-1:0]    main_n,
  input logic [A_W-1:0]    main_a,
  input logic              out_test,
  input logic [SEL_W-1:0]  ld_sel
);
  // R6
  short_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb_rise && !word_full |-> !load_ref && !load_main);
  // R5
  bad_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb_rise && !shift_word[1] |-> !load_ref && !load_main);
  // R3
  ref_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_ref |=> ref_div == $past(shift_word[R_LSB +: R_W]));
  // R4
  main_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_main |=> main_n == $past(shift_word[N_LSB +: N_W]) && main_a == $past(shift_word[A_LSB +: A_W]));
  // R7
  ref_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_ref |=> $stable(ref_div));
  // R7
  main_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_main |=> $stable(main_n) && $stable(main_a));
  // R8
  ld_normal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_test |-> ld_sel == '0);
endmodule

bind synth_prog_if synth_prog_chk u_chk (
  .clk(clk), .rst_n(rst_n), .stb_rise(stb_rise), .word_full(word_full),
  .load_ref(load_ref), .load_main(load_main), .shift_word(shift_word),
  .ref_div(ref_div), .main_n(main_n), .main_a(main_a),
  .out_test(out_test), .ld_sel(ld_sel)
);

// File: tb/synth_prog_if_test.sv
`timescale 1ns/1ps
module synth_prog_if_test;
  logic clk = 0, rst_n = 0, ser_clk = 0, ser_data = 0, ser_strobe = 0;
  logic [13:0] ref_div; logic [1:0] test_sel; logic presc_sel, ctr_test, out_test;
  logic [10:0] main_n; logic [6:0] main_a; logic pd_pol; logic [2:0] ld_sel;
  int checks = 0, errors = 0;

  logic [13:0] e_r = 0; logic [1:0] e_t = 0; logic e_p = 0, e_tc = 0, e_to = 0;
  logic [10:0] e_n = 0; logic [6:0] e_a = 0; logic e_pd = 0;

  always #5 clk = ~clk;

  synth_prog_if uut (.*);

  function automatic logic [2:0] exp_sel(input logic to, input logic [1:0] t);
    if (!to) return 3'b000;
    return 3'b100 | {1'b0, t};
  endfunction

  // apply a word to the bench model (R3, R4, R5)
  task automatic model_load(input logic [22:0] w);
    if (w[1:0] == 2'b10) begin
      e_r = w[17:4]; e_t = w[3:2]; e_tc = w[20]; e_to = w[21]; e_p = w[22];
    end else if (w[1:0] == 2'b11) begin
      e_n = w[22:12]; e_a = w[11:5]; e_pd = w[4];
    end
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    chk({req, " ref_div"}, 32'(ref_div), 32'(e_r));
    chk({req, " test_sel"}, 32'(test_sel), 32'(e_t));
    chk({req, " presc_sel"}, 32'(presc_sel), 32'(e_p));
    chk({req, " ctr_test"}, 32'(ctr_test), 32'(e_tc));
    chk({req, " out_test"}, 32'(out_test), 32'(e_to));
    chk({req, " main_n"}, 32'(main_n), 32'(e_n));
    chk({req, " main_a"}, 32'(main_a), 32'(e_a));
    chk({req, " pd_pol"}, 32'(pd_pol), 32'(e_pd));
    chk({req, " R8 ld_sel"}, 32'(ld_sel), 32'(exp_sel(e_to, e_t)));
  endtask

  task automatic send_bits(input logic [63:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      @(negedge clk); ser_data = v[i]; ser_clk = 0;
      repeat (3) @(negedge clk);
      ser_clk = 1;
      repeat (3) @(negedge clk);
      ser_clk = 0;
    end
  endtask

  task automatic strobe();
    @(negedge clk); ser_strobe = 1;
    repeat (3) @(negedge clk);
    ser_strobe = 0;
    repeat (6) @(negedge clk);
  endtask

  task automatic send_word(input logic [22:0] w);
    send_bits(64'(w), 23);
    strobe();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [22:0] w;
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    check_all("R1 reset");

    // R3 directed: all ones to reference latch
    w = 23'h7FFFFE; send_word(w); model_load(w); check_all("R3 ones");
    // R4 directed: alternating bits to main latch, R7 reference stays
    w = {21'h0AAAAA, 2'b11}; send_word(w); model_load(w); check_all("R4 R7 alt");
    // R8: walk test select values with output test on, then off
    for (int t = 0; t < 4; t++) begin
      w = {1'b0, 1'b1, 1'b0, 2'b00, 14'h1234, 2'(t), 2'b10};
      send_word(w); model_load(w); check_all("R8 walk");
    end
    w = {1'b1, 1'b0, 1'b1, 2'b00, 14'h0F0F, 2'b11, 2'b10};
    send_word(w); model_load(w); check_all("R8 off");
    // R5: codes 00 and 01 ignored
    send_word(23'h7FFFFC); check_all("R5 code00");
    send_word(23'h555555 & 23'h7FFFFD | 23'h1); check_all("R5 code01");
    // R6: short burst then strobe ignored
    send_bits(64'h3FF, 10); strobe(); check_all("R6 short");
    // R6: 13 more bits after a strobe are not enough either
    send_bits(64'h1FFF, 13); strobe(); check_all("R6 restart");
    // R2: 30-bit burst, last 23 count
    w = {11'h2C3, 7'h5A, 1'b1, 2'b00, 2'b11};
    send_bits({7'h7F, w}, 30); strobe(); model_load(w); check_all("R2 long");
    // random words, all codes
    for (int k = 0; k < 50; k++) begin
      w = 23'($urandom);
      send_word(w); model_load(w); check_all("R2 R3 R4 R5 R7 random");
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule